// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block sits in the read path of a byte-wide flash device. It reports the state of an internal program or erase while that operation runs. An accepted start strobe launches an internal operation: byte program, sector erase or chip erase. A cycle counter stands in for the real write timer and holds the block busy for a configurable number of clocks, with one count for each kind of operation.

While the block is busy, a host read does not see array contents on the two top data bits. The top bit carries a polling value: the inverted top bit of the byte being programmed, or zero during an erase. The bit below it flips once per read access. A host can therefore poll either bit until it stops reading busy. When the block is idle, every bit of the array word passes straight through.

Reads are synchronous. The chip select and output enable inputs are active low and are sampled on the clock. The data and the drive flag appear one cycle after the inputs are sampled. The drive flag stands in for a tri-state output enable.

Top module: `flash_status_poll`

## Requirements
- R1: An accepted start strobe raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles, for `startOp` values 0, 1 and 2.
- R2: The block ignores a start strobe that arrives while `busy` is high, and it ignores `startOp` = 3 at any time. Neither changes the busy length nor the polling value of the running operation.
- R3: During a program, bit 7 of read data is the complement of bit 7 of the byte latched at start.
- R4: During either kind of erase, bit 7 of read data is 0.
- R5: During any operation, bit 6 of read data takes the opposite value on each new read access and stays constant within an access. Its state is kept between accesses and while idle, and it starts from 0 after reset, so the first busy access after reset reads 1.
- R6: While idle, read data equals `arrayData` on all eight bits. This includes the first access after `busy` falls.
- R7: `rdDrive` is high one cycle after `ceN` and `oeN` are both sampled low. Otherwise `rdDrive` is low and `rdData` is zero.
- R8: While busy, bits 5 to 0 of read data pass `arrayData` through.
- R9: During reset, `busy`, `rdDrive` and `rdData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle request to begin an internal operation |
| startOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 no operation |
| progByte | input | 8 | Byte being programmed, latched on an accepted start |
| arrayData | input | 8 | Word read from the storage array |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| busy | output | 1 | Internal operation in progress |
| rdData | output | 8 | Read data, zero when not driven |
| rdDrive | output | 1 | Read data is being driven |

## Verification
The hardest case to reach is a read access that is already open when `busy` falls. Bit 6 must stay put inside that access, yet the data must switch to the true array word. The bench covers this by running back-to-back accesses separated by one half-select cycle through every busy window, for all three operation kinds and several byte patterns, so access edges land on every phase of the countdown. The same bench also fires ignored start strobes into a running operation, with a byte whose top bit differs, and checks that neither the polling bit nor the busy length changes.

// File: rtl/flash_status_poll_pkg.sv
package flash_status_poll_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadByte;   // accepted start, latch the program byte
    logic busy;       // internal operation in progress
    logic eraseOp;    // running operation is an erase
    logic readNow;    // qualified read this cycle
    logic togBit;     // toggle value to present for this access
  } pollStrobe_t;

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import flash_status_poll_pkg::*;
#(
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 60,
  parameter int CHIP_CYCLES = 150
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [1:0]  startOp,
  input  logic        ceN,
  input  logic        oeN,
  output pollStrobe_t strobe
);

  localparam int MAX_A   = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAX_CYC = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  opKind_t          opIn;
  logic             accept;
  logic [CNT_W-1:0] loadCount;
  logic [CNT_W-1:0] remCnt;
  logic             busyQ;
  logic             eraseQ;
  logic             readPrev;
  logic             togQ;
  logic             readNow;
  logic             readEdge;
  logic             togNext;

  assign opIn     = opKind_t'(startOp);
  assign accept   = startPulse && !busyQ && (opIn != OP_NONE);
  assign readNow  = !ceN && !oeN;
  assign readEdge = readNow && !readPrev;
  assign togNext  = togQ ^ (readEdge && busyQ);

  always_comb begin
    case (opIn)
      OP_PROG: loadCount = CNT_W'(PROG_CYCLES);
      OP_SECT: loadCount = CNT_W'(SECT_CYCLES);
      OP_CHIP: loadCount = CNT_W'(CHIP_CYCLES);
      default: loadCount = '0;
    endcase
  end

  // Operation timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      remCnt <= '0;
      eraseQ <= 1'b0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      remCnt <= loadCount;
      eraseQ <= (opIn != OP_PROG);
    end else if (busyQ) begin
      remCnt <= remCnt - CNT_W'(1);
      if (remCnt == CNT_W'(1)) busyQ <= 1'b0;
    end
  end

  // Read access edge and toggle state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b0;
      togQ     <= 1'b0;
    end else begin
      readPrev <= readNow;
      togQ     <= togNext;
    end
  end

  assign strobe.loadByte = accept;
  assign strobe.busy     = busyQ;
  assign strobe.eraseOp  = eraseQ;
  assign strobe.readNow  = readNow;
  assign strobe.togBit   = togNext;

endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import flash_status_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strobe,
  input  logic [DATA_W-1:0] progByte,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  localparam int POLL_HI = DATA_W - 1;
  localparam int TOG_POS = DATA_W - 2;

  logic              pollSrc;
  logic [DATA_W-1:0] composed;
  logic [DATA_W-1:0] dataQ;
  logic              driveQ;
  logic              unusedLow;

  assign unusedLow = ^progByte[TOG_POS:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pollSrc <= 1'b0;
    else if (strobe.loadByte) pollSrc <= progByte[POLL_HI];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_HI) begin : g_poll
      assign composed[b] = strobe.busy ? (!strobe.eraseOp && !pollSrc) : arrayData[b];
    end else if (b == TOG_POS) begin : g_tog
      assign composed[b] = strobe.busy ? strobe.togBit : arrayData[b];
    end else begin : g_pass
      assign composed[b] = arrayData[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      driveQ <= 1'b0;
    end else begin
      driveQ <= strobe.readNow;
      dataQ  <= strobe.readNow ? composed : '0;
    end
  end

  assign rdData  = dataQ;
  assign rdDrive = driveQ;

endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
  import flash_status_poll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 60,
  parameter int CHIP_CYCLES = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        startOp,
  input  logic [DATA_W-1:0] progByte,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              ceN,
  input  logic              oeN,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  pollStrobe_t strobe;

  fsp_ctrl #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .CHIP_CYCLES(CHIP_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .startOp   (startOp),
    .ceN       (ceN),
    .oeN       (oeN),
    .strobe    (strobe)
  );

  fsp_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .progByte (progByte),
    .arrayData(arrayData),
    .rdData   (rdData),
    .rdDrive  (rdDrive)
  );

  assign busy = strobe.busy;

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic [1:0] startOp,
  input logic [7:0] progByte,
  input logic [7:0] arrayData,
  input logic       ceN,
  input logic       oeN,
  input logic       busy,
  input logic [7:0] rdData,
  input logic       rdDrive
);

  logic rd;
  logic armed;
  logic lastErase;
  logic lastBit7;

  assign rd = !ceN && !oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      lastErase <= 1'b0;
      lastBit7  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (startPulse && !busy && startOp != 2'd3) begin
        lastErase <= (startOp != 2'd0);
        lastBit7  <= progByte[7];
      end
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && startOp != 2'd3) |=> busy);

  p_ignore_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && startOp == 2'd3) |=> !busy);

  p_prog_bit7_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rd && !lastErase) |=> (rdData[7] == !lastBit7));

  p_erase_bit7_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rd && lastErase) |=> !rdData[7]);

  p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && busy && rd && $past(busy) && $past(rd)) |=> (rdData[6] == $past(rdData[6])));

  p_idle_true_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rd) |=> (rdData == $past(arrayData)));

  p_no_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rd |=> (!rdDrive && rdData == 8'h00));

  p_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    rd |=> rdDrive);

endmodule

bind flash_status_poll fsp_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .startOp   (startOp),
  .progByte  (progByte),
  .arrayData (arrayData),
  .ceN       (ceN),
  .oeN       (oeN),
  .busy      (busy),
  .rdData    (rdData),
  .rdDrive   (rdDrive)
);

// File: tb/sim_flash_status_poll.sv
`timescale 1ns/1ps
module sim_flash_status_poll;

  localparam int P_CYC = 12;
  localparam int S_CYC = 30;
  localparam int C_CYC = 45;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] startOp = 2'd0;
  logic [7:0] progByte = 8'h00;
  logic [7:0] arrayData = 8'h00;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic       busy;
  logic [7:0] rdData;
  logic       rdDrive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state
  bit    busyM = 1'b0;
  int    remM = 0;
  bit    eraseM = 1'b0;
  bit    bit7M = 1'b0;
  bit    togM = 1'b0;
  bit    prevRd = 1'b0;
  int    seedV = 0;
  string scenTag = "";

  always #4 clk = ~clk;

  flash_status_poll #(
    .DATA_W(8), .PROG_CYCLES(P_CYC), .SECT_CYCLES(S_CYC), .CHIP_CYCLES(C_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startOp(startOp),
    .progByte(progByte), .arrayData(arrayData), .ceN(ceN), .oeN(oeN),
    .busy(busy), .rdData(rdData), .rdDrive(rdDrive)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pick(input string dflt);
    return (scenTag != "") ? scenTag : dflt;
  endfunction

  // One clock: model from current inputs, then compare after the edge
  task automatic tick();
    bit rd;
    bit busyPre;
    bit eraseUse;
    bit b7;
    bit [7:0] arr;
    rd       = !ceN && !oeN;
    busyPre  = busyM;
    eraseUse = eraseM;
    b7       = bit7M;
    arr      = arrayData;
    if (rd && busyPre && !prevRd) togM = ~togM;
    prevRd = rd;
    if (startPulse && !busyM && startOp != 2'd3) begin
      busyM  = 1'b1;
      remM   = (startOp == 2'd0) ? P_CYC : (startOp == 2'd1) ? S_CYC : C_CYC;
      eraseM = (startOp != 2'd0);
      bit7M  = progByte[7];
    end else if (busyM) begin
      if (remM == 1) busyM = 1'b0;
      remM--;
    end
    @(posedge clk);
    #1;
    chk(busy == busyM, pick("R1"), int'(busy), int'(busyM));
    chk(rdDrive == rd, "R7", int'(rdDrive), int'(rd));
    if (!rd) begin
      chk(rdData == 8'h00, "R7", int'(rdData), 0);
    end else if (!busyPre) begin
      chk(rdData == arr, pick("R6"), int'(rdData), int'(arr));
    end else begin
      chk(rdData[7] == (eraseUse ? 1'b0 : !b7), pick(eraseUse ? "R4" : "R3"),
          int'(rdData[7]), int'(eraseUse ? 1'b0 : !b7));
      chk(rdData[6] == togM, pick("R5"), int'(rdData[6]), int'(togM));
      chk(rdData[5:0] == arr[5:0], pick("R8"), int'(rdData[5:0]), int'(arr[5:0]));
    end
    @(negedge clk);
  endtask

  task automatic nextArray();
    seedV++;
    arrayData = 8'(seedV * 37 + 11);
  endtask

  task automatic readAccess(input int len);
    ceN = 1'b0; oeN = 1'b0;
    for (int i = 0; i < len; i++) begin
      nextArray();
      tick();
    end
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic halfSelect();
    ceN = 1'b0; oeN = 1'b1;
    nextArray();
    tick();
    ceN = 1'b1;
  endtask

  task automatic launch(input logic [1:0] op, input logic [7:0] b);
    startPulse = 1'b1; startOp = op; progByte = b;
    tick();
    startPulse = 1'b0; startOp = 2'd0; progByte = 8'h00;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R9", int'(busy), 0);
    chk(rdDrive == 1'b0, "R9", int'(rdDrive), 0);
    chk(rdData == 8'h00, "R9", int'(rdData), 0);
    @(negedge clk);
    rstN = 1'b1;
    tick();

    // R6 idle read, R7 half select
    readAccess(2);
    halfSelect();
    tick();

    // Sweep over operation kinds and byte patterns (R1 R3 R4 R5 R8 R6)
    for (int op = 0; op < 3; op++) begin
      for (int p = 0; p < 4; p++) begin
        launch(2'(op), {p[0], 7'(p * 29)});
        while (busyM) begin
          readAccess(1 + (p % 3));
          if (p[1]) halfSelect(); else tick();
        end
        readAccess(2);   // R6 first read after busy falls
        tick();
      end
    end

    // R2: start strobes during a running program are ignored
    launch(2'd0, 8'h00);
    readAccess(2);
    scenTag = "R2";
    launch(2'd1, 8'h80);
    readAccess(2);
    launch(2'd0, 8'h80);
    while (busyM) begin
      readAccess(2);
      tick();
    end
    readAccess(1);
    // R2: op code 3 is ignored while idle
    launch(2'd3, 8'hFF);
    for (int i = 0; i < 4; i++) tick();
    readAccess(2);
    scenTag = "";

    // R5: toggle state kept across idle into a fresh erase
    launch(2'd2, 8'h00);
    readAccess(3);
    tick();
    readAccess(2);
    while (busyM) tick();
    readAccess(1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule